// File: doc/BRIEF.md
# Package Low-Power State Controller

This block follows the low-power state of a processor package that holds several cores (two by default). Each core can halt on its own. The package enters its halted state only after every core has halted. Wake interrupts return the package to running. A clock-stop request parks the package in a stop-grant state and later releases it. Cache snoops are serviced from both the halted state and the stop-grant state. The bus clock runs in every state, so the block is plain synchronous logic. It uses one clock and a synchronous reset.

The surrounding chip supplies halt requests from the cores, the clock-stop request from the system, and a snoop request/done handshake from the coherence logic. It also supplies the wake interrupts and the return event of a system-management handler. The chip reads back the encoded state, the per-core halted flags, a one-cycle pulse that starts the halt bus cycle, a stop-grant acknowledge and a snoop-enable level.

Top module: `lowpower_ctl`

## Requirements
- R1: The state is encoded on 3 bits: Normal=0, Halt=1, Halt Snoop=2, Stop Grant=3, Stop Grant Snoop=4. After reset the state is Normal, all halted flags are 0, and `halt_cycle`, `stop_ack` and `snoop_en` are 0.
- R2: In Normal, a halt request from a core sets only that core's flag. The package stays in Normal while any flag is still clear.
- R3: The package moves from Normal to Halt on the clock edge at which the last flag would become set. Every flag is 1 while in Halt. `halt_cycle` is high for exactly the first cycle of every Halt entered from Normal.
- R4: Any bit of `wake_irq` (bit0 SMI, bit1 INIT, bit2 NMI, bit3 INTR, bit4 bus interrupt or message) returns Halt to Normal at the next edge and clears every flag. In Normal, a wake clears every flag.
- R5: `rst` high returns the block to Normal at the next edge, with all flags and outputs cleared. This holds from any state and `rst` overrides every other input.
- R6: `clk_stop_req` high in Normal or Halt moves the block to Stop Grant. When the request drops in Stop Grant, the block returns to the state it came from.
- R7: `stop_ack` rises one cycle after Stop Grant is entered. It stays high through Stop Grant Snoop and drops on the edge that leaves the stop-grant states.
- R8: `snoop_req` moves Halt to Halt Snoop and Stop Grant to Stop Grant Snoop. `snoop_done` returns each snoop state to the state it came from. A further `snoop_req` during a snoop has no effect.
- R9: `snoop_en` is high exactly when the state is not Normal.
- R10: In Normal, when `smi_ret` is high, `smi_ret_halt`=1 sends the package to Halt with every flag set. `smi_ret_halt`=0 keeps it in Normal.
- R11: A wake seen in Stop Grant or Stop Grant Snoop is held as pending. When the clock-stop request drops, a pending wake sends the block to Normal with every flag cleared, even if Stop Grant was entered from Halt.
- R12: In Halt, a wake has priority over the clock-stop request, and the clock-stop request has priority over a snoop request. In Halt Snoop, only `snoop_done` acts; wakes and clock-stop requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| core_halt_req | input | NCORES | Per-core halt request |
| clk_stop_req | input | 1 | Clock-stop request level |
| snoop_req | input | 1 | Snoop request |
| snoop_done | input | 1 | Snoop serviced |
| wake_irq | input | NWAKE | Wake interrupts |
| smi_ret | input | 1 | Management handler return event |
| smi_ret_halt | input | 1 | Return target: 1 = Halt, 0 = Normal |
| state_o | output | 3 | Encoded package state |
| core_halted | output | NCORES | Per-core halted flags |
| halt_cycle | output | 1 | One-cycle halt bus-cycle pulse |
| stop_ack | output | 1 | Stop-grant acknowledge |
| snoop_en | output | 1 | Snoops may be serviced |

## Verification
The stop-grant origin bit and the pending-wake bit are not visible at any port. An error in either one shows only when the clock-stop request drops: the package lands in the wrong state on that same edge. The bench therefore leaves Stop Grant from both origins, with and without a pending wake. A wrong halted-flag vector shows one edge after the halt request, because the package enters Halt too early or too late. A wrong snoop return state shows on the edge after `snoop_done`.

// File: rtl/lowpower_ctl.sv
module lowpower_ctl #(
  parameter int NCORES = 2,
  parameter int NWAKE  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCORES-1:0] core_halt_req,
  input  logic              clk_stop_req,
  input  logic              snoop_req,
  input  logic              snoop_done,
  input  logic [NWAKE-1:0]  wake_irq,
  input  logic              smi_ret,
  input  logic              smi_ret_halt,
  output logic [2:0]        state_o,
  output logic [NCORES-1:0] core_halted,
  output logic              halt_cycle,
  output logic              stop_ack,
  output logic              snoop_en
);
  localparam logic [2:0] S_NORM = 3'd0;
  localparam logic [2:0] S_HALT = 3'd1;
  localparam logic [2:0] S_HSNP = 3'd2;
  localparam logic [2:0] S_SG   = 3'd3;
  localparam logic [2:0] S_SSNP = 3'd4;

  logic [2:0]        state, nxt;
  logic [NCORES-1:0] halted, nxt_halted, merged;
  logic              from_halt, nxt_from_halt;
  logic              pend, nxt_pend;
  logic              wake;

  assign wake   = |wake_irq;
  assign merged = halted | core_halt_req;

  always_comb begin
    nxt           = state;
    nxt_halted    = halted;
    nxt_from_halt = from_halt;
    nxt_pend      = pend;
    case (state)
      S_NORM: begin
        if (clk_stop_req) begin
          nxt           = S_SG;
          nxt_from_halt = 1'b0;
          nxt_pend      = 1'b0;
        end else if (wake) begin
          nxt_halted = '0;
        end else if (smi_ret && smi_ret_halt) begin
          nxt        = S_HALT;
          nxt_halted = '1;
        end else begin
          nxt_halted = merged;
          if (&merged) nxt = S_HALT;
        end
      end
      S_HALT: begin
        if (wake) begin
          nxt        = S_NORM;
          nxt_halted = '0;
        end else if (clk_stop_req) begin
          nxt           = S_SG;
          nxt_from_halt = 1'b1;
          nxt_pend      = 1'b0;
        end else if (snoop_req) begin
          nxt = S_HSNP;
        end
      end
      S_HSNP: if (snoop_done) nxt = S_HALT;
      S_SG: begin
        if (!clk_stop_req) begin
          nxt_pend = 1'b0;
          if (from_halt && !pend) nxt = S_HALT;
          else begin
            nxt        = S_NORM;
            nxt_halted = '0;
          end
        end else begin
          nxt_pend = pend | wake;
          if (snoop_req) nxt = S_SSNP;
        end
      end
      S_SSNP: begin
        nxt_pend = pend | wake;
        if (snoop_done) nxt = S_SG;
      end
      default: nxt = S_NORM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_NORM;
      halted     <= '0;
      from_halt  <= 1'b0;
      pend       <= 1'b0;
      halt_cycle <= 1'b0;
      stop_ack   <= 1'b0;
    end else begin
      state      <= nxt;
      halted     <= nxt_halted;
      from_halt  <= nxt_from_halt;
      pend       <= nxt_pend;
      halt_cycle <= (state == S_NORM) && (nxt == S_HALT);
      stop_ack   <= (state == S_SG || state == S_SSNP) && (nxt == S_SG || nxt == S_SSNP);
    end
  end

  assign state_o     = state;
  assign core_halted = halted;
  assign snoop_en    = (state != S_NORM);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst) state_o <= 3'd4); // R1
  AST_HALT_ALL: assert property (@(posedge clk) disable iff (rst) (state_o == S_HALT) |-> (&core_halted)); // R3
  AST_PULSE_ENTRY: assert property (@(posedge clk) disable iff (rst) halt_cycle |-> (state_o == S_HALT && $past(state_o) == S_NORM)); // R3
  AST_WAKE_HALT: assert property (@(posedge clk) disable iff (rst) (state_o == S_HALT && wake) |=> (state_o == S_NORM && core_halted == '0)); // R4
  AST_RST_WINS: assert property (@(posedge clk) rst |=> (state_o == S_NORM && core_halted == '0 && !stop_ack && !halt_cycle)); // R5
  AST_ACK_SG: assert property (@(posedge clk) disable iff (rst) stop_ack |-> ((state_o == S_SG || state_o == S_SSNP) && ($past(state_o) == S_SG || $past(state_o) == S_SSNP))); // R7
  AST_SNOOP_HOLD: assert property (@(posedge clk) disable iff (rst) (state_o == S_HSNP && !snoop_done) |=> (state_o == S_HSNP)); // R8
endmodule

// File: tb/sim_lowpower_ctl.sv
module sim_lowpower_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] core_halt_req = '0;
  logic       clk_stop_req = 1'b0, snoop_req = 1'b0, snoop_done = 1'b0;
  logic [4:0] wake_irq = '0;
  logic       smi_ret = 1'b0, smi_ret_halt = 1'b0;
  logic [2:0] state_o;
  logic [1:0] core_halted;
  logic       halt_cycle, stop_ack, snoop_en;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] st;
    logic [1:0] hl;
    logic       pl, ack, sen;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  lowpower_ctl u0 (
    .clk(clk), .rst(rst), .core_halt_req(core_halt_req), .clk_stop_req(clk_stop_req),
    .snoop_req(snoop_req), .snoop_done(snoop_done), .wake_irq(wake_irq),
    .smi_ret(smi_ret), .smi_ret_halt(smi_ret_halt), .state_o(state_o),
    .core_halted(core_halted), .halt_cycle(halt_cycle), .stop_ack(stop_ack), .snoop_en(snoop_en)
  );

  task automatic step(input logic r, input logic [1:0] hr, input logic stp, input logic sr,
                      input logic sd, input logic [4:0] wk, input logic sret, input logic srh,
                      input logic [2:0] st, input logic [1:0] hl, input logic pl, input logic ack,
                      input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; core_halt_req = hr; clk_stop_req = stp; snoop_req = sr; snoop_done = sd;
    wake_irq = wk; smi_ret = sret; smi_ret_halt = srh;
    @(posedge clk);
    #1;
    e.st = st; e.hl = hl; e.pl = pl; e.ack = ack; e.sen = (st != 3'd0); e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (state_o !== e.st) begin fails++; $display("FAIL %s state: got %0d exp %0d", e.tag, state_o, e.st); end
      tests++;
      if (core_halted !== e.hl) begin fails++; $display("FAIL %s halted: got %b exp %b", e.tag, core_halted, e.hl); end
      tests++;
      if (halt_cycle !== e.pl) begin fails++; $display("FAIL %s halt_cycle: got %b exp %b", e.tag, halt_cycle, e.pl); end
      tests++;
      if (stop_ack !== e.ack) begin fails++; $display("FAIL %s stop_ack: got %b exp %b", e.tag, stop_ack, e.ack); end
      tests++;
      if (snoop_en !== e.sen) begin fails++; $display("FAIL R9 (%s) snoop_en: got %b exp %b", e.tag, snoop_en, e.sen); end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    //   rst hreq  stp sr sd wake      sret srh  st    hl     pl ack tag
    step(1, 2'b00, 0, 0, 0, 5'b00000, 0, 0, 3'd0, 2'b00, 0, 0, "R1 reset");
    step(0, 2'b01, 0, 0, 0, 5'b00000, 0, 0, 3'd0, 2'b01, 0, 0, "R2 core0 halts");
    step(0, 2'b00, 0, 0, 0, 5'b00000, 0, 0, 3'd0, 2'b01, 0, 0, "R2 still normal");
    step(0, 2'b10, 0, 0, 0, 5'b00000, 0, 0, 3'd1, 2'b11, 1, 0, "R3 all halted");
    step(0, 2'b00, 0, 0, 0, 5'b00000, 0, 0, 3'd1, 2'b11, 0, 0, "R3 pulse one cycle");
    step(0, 2'b00, 0, 0, 0, 5'b00100, 0, 0, 3'd0, 2'b00, 0, 0, "R4 nmi wake");
    step(0, 2'b11, 0, 0, 0, 5'b00000, 0, 0, 3'd1, 2'b11, 1, 0, "R3 both at once");
    step(0, 2'b00, 1, 0, 0, 5'b00000, 0, 0, 3'd3, 2'b11, 0, 0, "R6 halt to stopgrant");
    step(0, 2'b00, 1, 0, 0, 5'b00000, 0, 0, 3'd3, 2'b11, 0, 1, "R7 ack rises");
    step(0, 2'b00, 1, 1, 0, 5'b00000, 0, 0, 3'd4, 2'b11, 0, 1, "R8 sg snoop");
    step(0, 2'b00, 1, 1, 0, 5'b00000, 0, 0, 3'd4, 2'b11, 0, 1, "R8 repeat req ignored");
    step(0, 2'b00, 1, 0, 1, 5'b00000, 0, 0, 3'd3, 2'b11, 0, 1, "R8 sg snoop done");
    step(0, 2'b00, 0, 0, 0, 5'b00000, 0, 0, 3'd1, 2'b11, 0, 0, "R6 back to halt");
    step(0, 2'b00, 0, 1, 0, 5'b00000, 0, 0, 3'd2, 2'b11, 0, 0, "R8 halt snoop");
    step(0, 2'b00, 1, 1, 0, 5'b00001, 0, 0, 3'd2, 2'b11, 0, 0, "R12 halt snoop ignores");
    step(0, 2'b00, 0, 0, 1, 5'b00000, 0, 0, 3'd1, 2'b11, 0, 0, "R8 halt snoop done");
    step(0, 2'b00, 1, 1, 0, 5'b00001, 0, 0, 3'd0, 2'b00, 0, 0, "R12 wake wins");
    step(0, 2'b11, 0, 0, 0, 5'b00000, 0, 0, 3'd1, 2'b11, 1, 0, "R3 re-halt");
    step(0, 2'b00, 1, 1, 0, 5'b00000, 0, 0, 3'd3, 2'b11, 0, 0, "R12 stop over snoop");
    step(0, 2'b00, 1, 0, 0, 5'b10000, 0, 0, 3'd3, 2'b11, 0, 1, "R11 wake pending");
    step(0, 2'b00, 0, 0, 0, 5'b00000, 0, 0, 3'd0, 2'b00, 0, 0, "R11 pending exit");
    step(0, 2'b00, 1, 0, 0, 5'b00000, 0, 0, 3'd3, 2'b00, 0, 0, "R6 normal to stopgrant");
    step(0, 2'b00, 1, 0, 0, 5'b00000, 0, 0, 3'd3, 2'b00, 0, 1, "R7 ack from normal");
    step(0, 2'b00, 0, 0, 0, 5'b00000, 0, 0, 3'd0, 2'b00, 0, 0, "R6 back to normal");
    step(0, 2'b00, 0, 0, 0, 5'b00000, 1, 1, 3'd1, 2'b11, 1, 0, "R10 return to halt");
    step(0, 2'b00, 0, 0, 0, 5'b01000, 0, 0, 3'd0, 2'b00, 0, 0, "R4 intr wake");
    step(0, 2'b00, 0, 0, 0, 5'b00000, 1, 0, 3'd0, 2'b00, 0, 0, "R10 return to normal");
    step(0, 2'b01, 0, 0, 0, 5'b00000, 0, 0, 3'd0, 2'b01, 0, 0, "R2 core0 again");
    step(0, 2'b00, 0, 0, 0, 5'b00010, 0, 0, 3'd0, 2'b00, 0, 0, "R4 wake in normal");
    step(0, 2'b11, 0, 0, 0, 5'b00000, 0, 0, 3'd1, 2'b11, 1, 0, "R3 halt again");
    step(0, 2'b00, 0, 1, 0, 5'b00000, 0, 0, 3'd2, 2'b11, 0, 0, "R8 snoop before reset");
    step(1, 2'b11, 1, 1, 0, 5'b11111, 1, 1, 3'd0, 2'b00, 0, 0, "R5 reset from snoop");
    step(0, 2'b11, 0, 0, 0, 5'b00000, 0, 0, 3'd1, 2'b11, 1, 0, "R3 halt after reset");
    step(0, 2'b00, 1, 0, 0, 5'b00000, 0, 0, 3'd3, 2'b11, 0, 0, "R6 into stopgrant");
    step(0, 2'b00, 1, 0, 0, 5'b00000, 0, 0, 3'd3, 2'b11, 0, 1, "R7 ack high");
    step(1, 2'b00, 1, 0, 0, 5'b00000, 0, 0, 3'd0, 2'b00, 0, 0, "R5 reset from stopgrant");
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule